// File: doc/BRIEF.md
# Circular Buffer DMA Address Generator

This block is the address and byte-count engine for a set of bus-master DMA channels. Each channel moves bytes between a circular buffer in system memory and an internal data path. It holds a buffer start address, a running address, a buffer size in bytes and a running count of the bytes left before the buffer end. While the channel runs it presents one request at a time. The request carries an address and a length, and the length is the configured beat size clipped to the bytes that remain. When the bus side reports the beat complete, the pointers advance. At the buffer end the channel either reloads itself from the start and sets a sticky wrap flag, or stops.

Each channel also has a reloading 24-bit byte counter that raises a sticky interrupt flag every time a programmed number of bytes has moved. Software sets up a channel through a word-wide write port that takes a channel index and a register select. It reads any register back through a combinational read port. The lower-numbered channels are receive channels and the rest are transmit channels. The bus protocol, the data storage and the arbitration between channels sit outside this block.

Top module: `cbuf_dma_agen`

## Requirements
- R1: After reset every register of every channel reads zero, no request is valid, and no flag or interrupt is set.
- R2: A write to the control register (select 6) with bit 0 set starts the channel. From the next cycle the running address equals the start address (select 0), the running count equals the buffer size (select 2), and the interrupt countdown (select 5) equals the interrupt period (select 4). A write with bit 0 set to a running channel restarts it in the same way.
- R3: The control register holds run in bit 0, loop in bit 1 and the beat size in bytes in bits 9:2. A request is valid exactly when run is set, the running count is nonzero and the beat size is nonzero. The request address is the running address, and the request length is the smaller of the beat size and the running count.
- R4: A beat is accepted when the request is valid and the channel's done input is high. In the next cycle the running address has grown by the request length and the running count has shrunk by it.
- R5: When an accepted beat brings the running count to zero with loop set, the running address and running count reload from the start address and buffer size. The wrap flag (status bit 0, select 7) is also set.
- R6: When an accepted beat brings the running count to zero with loop clear, run clears and requests stop. The running address is left at one past the buffer end, and the wrap flag stays unchanged.
- R7: Each accepted beat lowers the interrupt countdown by the request length, saturating at zero. When a nonzero countdown reaches zero, it reloads from the interrupt period and the interrupt flag (status bit 1) is set. The output irq_o is the OR of all channels' interrupt flags.
- R8: A write to the status register (select 7) clears each flag whose bit is written as one, and leaves flags written as zero untouched. When a flag is set and cleared in the same cycle, it ends up set.
- R9: Channels with an index below NUM_RX report req_rx_o high, meaning receive. All other channels report it low, meaning transmit.
- R10: A control write with bit 0 clear stops requests from the next cycle, and the running address and running count keep their values.
- R11: A configuration write changes only the channel selected by cfg_ch_i.
- R12: A done input that arrives while its channel has no valid request changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_ch_i | input | CH_W | Channel index for the write |
| cfg_sel_i | input | 3 | Register select for the write |
| cfg_wdata_i | input | AW | Write data |
| rd_ch_i | input | CH_W | Channel index for readback |
| rd_sel_i | input | 3 | Register select for readback |
| rd_data_o | output | AW | Readback data, zero-extended |
| req_valid_o | output | NUM_CH | Request valid, one bit per channel |
| req_addr_o | output | NUM_CH*AW | Request address per channel |
| req_len_o | output | NUM_CH*LEN_W | Request length in bytes per channel |
| req_rx_o | output | NUM_CH | Channel direction, 1 means receive |
| done_i | input | NUM_CH | Beat completed, one bit per channel |
| wrap_sts_o | output | NUM_CH | Sticky wrap flag per channel |
| irq_flag_o | output | NUM_CH | Sticky interrupt flag per channel |
| irq_o | output | 1 | Any channel interrupt flag set |

## Verification
Register writes, starts, stops and accepted beats all take effect at the first rising edge after they are driven. Their results appear on the request outputs, the flags and the readback port one cycle later. Readback is combinational on the present register state. The bench drives every strobe for exactly one cycle starting at a falling edge and samples at the next falling edge, after the single capturing edge has passed. This keeps each expected value aligned to the register it depends on. The same-cycle cases are driven in one cycle so they meet at a single edge: a flag set together with its clear, and a stray done while no request is valid.

// File: rtl/cbuf_dma_pkg.sv
package cbuf_dma_pkg;
  typedef enum logic [2:0] {
    SEL_BASE_ADDR = 3'd0,
    SEL_CUR_ADDR  = 3'd1,
    SEL_BASE_CNT  = 3'd2,
    SEL_CUR_CNT   = 3'd3,
    SEL_IRQ_BASE  = 3'd4,
    SEL_IRQ_CUR   = 3'd5,
    SEL_CTRL      = 3'd6,
    SEL_STAT      = 3'd7
  } sel_e;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_LOOP_BIT = 1;
  localparam int unsigned CTRL_BEAT_LSB = 2;
  localparam int unsigned STAT_WRAP_BIT = 0;
  localparam int unsigned STAT_IRQ_BIT  = 1;
endpackage

// File: rtl/cbuf_dma_irq_ctr.sv
module cbuf_dma_irq_ctr #(
  parameter int unsigned W     = 24,
  parameter int unsigned STEP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [W-1:0]      base_d_i,
  input  logic              load_i,
  input  logic              step_en_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              clr_i,
  output logic [W-1:0]      base_o,
  output logic [W-1:0]      cur_o,
  output logic              flag_o
);
  logic [W-1:0] base_q, cur_q, step_w;
  logic         hit;
  logic         flag_q;

  assign step_w = {{(W-STEP_W){1'b0}}, step_i};
  // countdown reaches zero from a nonzero value
  assign hit = step_en_i && !load_i && (cur_q != '0) && (cur_q <= step_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (base_we_i) begin
      base_q <= base_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
    end else if (load_i) begin
      cur_q <= base_q;
    end else if (hit) begin
      cur_q <= base_q;
    end else if (step_en_i) begin
      cur_q <= (cur_q > step_w) ? cur_q - step_w : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= hit | (flag_q & ~clr_i);
  end

  assign base_o = base_q;
  assign cur_o  = cur_q;
  assign flag_o = flag_q;

  assert_irq_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && !load_i && !base_we_i && cur_q != '0 && cur_q <= step_w)
      |=> (cur_q == $past(base_q) && flag_q));

  assert_irq_countdown_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && !load_i && cur_q > step_w) |=> (cur_q == $past(cur_q) - $past(step_w)));

  assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/cbuf_dma_chan.sv
module cbuf_dma_chan
  import cbuf_dma_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 24,
  parameter int unsigned IRQ_W = 24,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [AW-1:0]    wr_data_i,
  input  logic [2:0]       rd_sel_i,
  output logic [AW-1:0]    rd_data_o,
  input  logic             done_i,
  output logic             req_valid_o,
  output logic [AW-1:0]    req_addr_o,
  output logic [LEN_W-1:0] req_len_o,
  output logic             wrap_o,
  output logic             irq_flag_o
);
  logic [AW-1:0]    base_addr_q, cur_addr_q, len_aw;
  logic [CNT_W-1:0] base_cnt_q, cur_cnt_q, beat_cnt, len_cnt, cnt_next;
  logic [LEN_W-1:0] beat_q;
  logic             run_q, loop_q, wrap_q;
  logic             ctrl_wr, start, stat_wr, accept, end_hit;
  logic [IRQ_W-1:0] irq_base, irq_cur;
  sel_e             wsel, rsel;

  assign wsel    = sel_e'(wr_sel_i);
  assign rsel    = sel_e'(rd_sel_i);
  assign ctrl_wr = wr_en_i && (wsel == SEL_CTRL);
  assign start   = ctrl_wr && wr_data_i[CTRL_RUN_BIT];
  assign stat_wr = wr_en_i && (wsel == SEL_STAT);

  assign beat_cnt = {{(CNT_W-LEN_W){1'b0}}, beat_q};
  assign len_cnt  = (cur_cnt_q < beat_cnt) ? cur_cnt_q : beat_cnt;
  assign len_aw   = {{(AW-CNT_W){1'b0}}, len_cnt};
  assign cnt_next = cur_cnt_q - len_cnt;

  assign req_valid_o = run_q && (cur_cnt_q != '0) && (beat_q != '0);
  assign req_addr_o  = cur_addr_q;
  assign req_len_o   = len_cnt[LEN_W-1:0];
  assign accept      = req_valid_o && done_i;
  assign end_hit     = accept && (cnt_next == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
    end else if (wr_en_i) begin
      if (wsel == SEL_BASE_ADDR) base_addr_q <= wr_data_i;
      if (wsel == SEL_BASE_CNT)  base_cnt_q  <= wr_data_i[CNT_W-1:0];
    end
  end

  // control write outranks a completing beat in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      loop_q     <= 1'b0;
      beat_q     <= '0;
      cur_addr_q <= '0;
      cur_cnt_q  <= '0;
    end else if (ctrl_wr) begin
      run_q  <= wr_data_i[CTRL_RUN_BIT];
      loop_q <= wr_data_i[CTRL_LOOP_BIT];
      beat_q <= wr_data_i[CTRL_BEAT_LSB +: LEN_W];
      if (start) begin
        cur_addr_q <= base_addr_q;
        cur_cnt_q  <= base_cnt_q;
      end
    end else if (accept) begin
      if (end_hit && loop_q) begin
        cur_addr_q <= base_addr_q;
        cur_cnt_q  <= base_cnt_q;
      end else begin
        cur_addr_q <= cur_addr_q + len_aw;
        cur_cnt_q  <= cnt_next;
        if (end_hit) run_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wrap_q <= 1'b0;
    else wrap_q <= (end_hit && loop_q && !ctrl_wr)
                 | (wrap_q & ~(stat_wr & wr_data_i[STAT_WRAP_BIT]));
  end

  cbuf_dma_irq_ctr #(.W(IRQ_W), .STEP_W(LEN_W)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .base_we_i (wr_en_i && (wsel == SEL_IRQ_BASE)),
    .base_d_i  (wr_data_i[IRQ_W-1:0]),
    .load_i    (start),
    .step_en_i (accept && !ctrl_wr),
    .step_i    (len_cnt[LEN_W-1:0]),
    .clr_i     (stat_wr && wr_data_i[STAT_IRQ_BIT]),
    .base_o    (irq_base),
    .cur_o     (irq_cur),
    .flag_o    (irq_flag_o)
  );

  assign wrap_o = wrap_q;

  always_comb begin
    unique case (rsel)
      SEL_BASE_ADDR: rd_data_o = base_addr_q;
      SEL_CUR_ADDR:  rd_data_o = cur_addr_q;
      SEL_BASE_CNT:  rd_data_o = {{(AW-CNT_W){1'b0}}, base_cnt_q};
      SEL_CUR_CNT:   rd_data_o = {{(AW-CNT_W){1'b0}}, cur_cnt_q};
      SEL_IRQ_BASE:  rd_data_o = {{(AW-IRQ_W){1'b0}}, irq_base};
      SEL_IRQ_CUR:   rd_data_o = {{(AW-IRQ_W){1'b0}}, irq_cur};
      SEL_CTRL:      rd_data_o = {{(AW-LEN_W-2){1'b0}}, beat_q, loop_q, run_q};
      default:       rd_data_o = {{(AW-2){1'b0}}, irq_flag_o, wrap_q};
    endcase
  end

  assert_start_copy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (cur_addr_q == $past(base_addr_q) && cur_cnt_q == $past(base_cnt_q)));

  assert_len_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_len_o != '0 && len_cnt <= cur_cnt_q && req_len_o <= beat_q));

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !ctrl_wr && !end_hit) |=>
      (cur_addr_q == $past(cur_addr_q + len_aw) && cur_cnt_q == $past(cur_cnt_q - len_cnt)));

  assert_wrap_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_hit && loop_q && !ctrl_wr) |=>
      (cur_addr_q == $past(base_addr_q) && cur_cnt_q == $past(base_cnt_q) && wrap_q));

  assert_end_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_hit && !loop_q && !ctrl_wr) |=> (!run_q && !req_valid_o));

  assert_stop_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wr_data_i[CTRL_RUN_BIT]) |=> (!req_valid_o && $stable(cur_addr_q)));

  assert_idle_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_o && !wr_en_i) |=> ($stable(cur_addr_q) && $stable(cur_cnt_q)));
endmodule

// File: rtl/cbuf_dma_agen.sv
module cbuf_dma_agen
  import cbuf_dma_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned NUM_RX = 2,
  parameter int unsigned AW     = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned IRQ_W  = 24,
  parameter int unsigned LEN_W  = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [CH_W-1:0]         cfg_ch_i,
  input  logic [2:0]              cfg_sel_i,
  input  logic [AW-1:0]           cfg_wdata_i,
  input  logic [CH_W-1:0]         rd_ch_i,
  input  logic [2:0]              rd_sel_i,
  output logic [AW-1:0]           rd_data_o,
  output logic [NUM_CH-1:0]       req_valid_o,
  output logic [NUM_CH*AW-1:0]    req_addr_o,
  output logic [NUM_CH*LEN_W-1:0] req_len_o,
  output logic [NUM_CH-1:0]       req_rx_o,
  input  logic [NUM_CH-1:0]       done_i,
  output logic [NUM_CH-1:0]       wrap_sts_o,
  output logic [NUM_CH-1:0]       irq_flag_o,
  output logic                    irq_o
);
  localparam int unsigned CH_N = 1 << CH_W;

  logic [AW-1:0] rd_arr [CH_N];

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    if (g < NUM_CH) begin : g_live
      cbuf_dma_chan #(
        .AW(AW), .CNT_W(CNT_W), .IRQ_W(IRQ_W), .LEN_W(LEN_W)
      ) u_chan (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (cfg_we_i && (cfg_ch_i == CH_W'(g))),
        .wr_sel_i    (cfg_sel_i),
        .wr_data_i   (cfg_wdata_i),
        .rd_sel_i    (rd_sel_i),
        .rd_data_o   (rd_arr[g]),
        .done_i      (done_i[g]),
        .req_valid_o (req_valid_o[g]),
        .req_addr_o  (req_addr_o[g*AW +: AW]),
        .req_len_o   (req_len_o[g*LEN_W +: LEN_W]),
        .wrap_o      (wrap_sts_o[g]),
        .irq_flag_o  (irq_flag_o[g])
      );
      if (g < NUM_RX) begin : g_rx
        assign req_rx_o[g] = 1'b1;
      end else begin : g_tx
        assign req_rx_o[g] = 1'b0;
      end
    end else begin : g_pad
      assign rd_arr[g] = '0;
    end
  end

  assign rd_data_o = rd_arr[rd_ch_i];
  assign irq_o     = |irq_flag_o;

  assert_irq_any_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_o != '0) |-> irq_o);

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (req_valid_o == '0 && !irq_o));
endmodule

// File: tb/cbuf_dma_agen_test.sv
module cbuf_dma_agen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int AW = 32;
  localparam int LEN_W = 8;
  localparam int CH_W = 2;

  logic                    clk = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    cfg_we_i = 1'b0;
  logic [CH_W-1:0]         cfg_ch_i = '0;
  logic [2:0]              cfg_sel_i = '0;
  logic [AW-1:0]           cfg_wdata_i = '0;
  logic [CH_W-1:0]         rd_ch_i = '0;
  logic [2:0]              rd_sel_i = '0;
  logic [AW-1:0]           rd_data_o;
  logic [NUM_CH-1:0]       req_valid_o;
  logic [NUM_CH*AW-1:0]    req_addr_o;
  logic [NUM_CH*LEN_W-1:0] req_len_o;
  logic [NUM_CH-1:0]       req_rx_o;
  logic [NUM_CH-1:0]       done_i = '0;
  logic [NUM_CH-1:0]       wrap_sts_o;
  logic [NUM_CH-1:0]       irq_flag_o;
  logic                    irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbuf_dma_agen uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_ch_i(cfg_ch_i),
    .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i), .rd_ch_i(rd_ch_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .req_valid_o(req_valid_o),
    .req_addr_o(req_addr_o), .req_len_o(req_len_o), .req_rx_o(req_rx_o),
    .done_i(done_i), .wrap_sts_o(wrap_sts_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input int ch, input int sel, input logic [31:0] exp);
    rd_ch_i  = CH_W'(ch);
    rd_sel_i = 3'(sel);
    #1;
    chk(tag, rd_data_o, exp);
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_ch_i = CH_W'(ch); cfg_sel_i = 3'(sel); cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic beat(input int ch);
    @(negedge clk);
    done_i[ch] = 1'b1;
    @(negedge clk);
    done_i = '0;
  endtask

  function automatic logic [31:0] addr_of(input int ch);
    return req_addr_o[ch*AW +: AW];
  endfunction

  function automatic logic [31:0] len_of(input int ch);
    return 32'(req_len_o[ch*LEN_W +: LEN_W]);
  endfunction

  task automatic t_reset;
    for (int s = 0; s < 8; s++) rd_chk("R1 ch0 reg", 0, s, 32'h0);
    rd_chk("R1 ch3 cur addr", 3, 1, 32'h0);
    chk("R1 req_valid", 32'(req_valid_o), 32'h0);
    chk("R1 irq", 32'(irq_o), 32'h0);
    chk("R9 direction", 32'(req_rx_o), 32'h3);
  endtask

  task automatic t_loop_run;
    wr(0, 0, 32'h1000);
    wr(0, 2, 32'd10);
    wr(0, 4, 32'd6);
    wr(0, 6, (32'd4 << 2) | 32'h3);
    rd_chk("R2 cur addr", 0, 1, 32'h1000);
    rd_chk("R2 cur cnt", 0, 3, 32'd10);
    rd_chk("R2 irq cur", 0, 5, 32'd6);
    chk("R3 valid", 32'(req_valid_o[0]), 32'h1);
    chk("R3 addr", addr_of(0), 32'h1000);
    chk("R3 len", len_of(0), 32'd4);
    beat(0);
    chk("R4 addr", addr_of(0), 32'h1004);
    rd_chk("R4 cnt", 0, 3, 32'd6);
    rd_chk("R7 irq cur", 0, 5, 32'd2);
    beat(0);
    chk("R3 clipped len", len_of(0), 32'd2);
    rd_chk("R7 irq reload", 0, 5, 32'd6);
    chk("R7 flag", 32'(irq_flag_o[0]), 32'h1);
    chk("R7 irq_o", 32'(irq_o), 32'h1);
    beat(0);
    chk("R5 addr reload", addr_of(0), 32'h1000);
    rd_chk("R5 cnt reload", 0, 3, 32'd10);
    chk("R5 wrap set", 32'(wrap_sts_o[0]), 32'h1);
    rd_chk("R7 irq sat", 0, 5, 32'd4);
  endtask

  task automatic t_w1c;
    wr(0, 7, 32'h2);
    chk("R8 irq cleared", 32'(irq_flag_o[0]), 32'h0);
    chk("R8 wrap kept", 32'(wrap_sts_o[0]), 32'h1);
    chk("R8 irq_o low", 32'(irq_o), 32'h0);
    wr(0, 7, 32'h1);
    chk("R8 wrap cleared", 32'(wrap_sts_o[0]), 32'h0);
    // countdown 4 with 4-byte beat: set and clear in one cycle
    @(negedge clk);
    done_i[0] = 1'b1;
    cfg_we_i = 1'b1; cfg_ch_i = 2'd0; cfg_sel_i = 3'd7; cfg_wdata_i = 32'h2;
    @(negedge clk);
    done_i = '0; cfg_we_i = 1'b0;
    chk("R8 set wins", 32'(irq_flag_o[0]), 32'h1);
    chk("R4 addr same cycle", addr_of(0), 32'h1004);
    wr(0, 7, 32'h2);
    chk("R8 clear after", 32'(irq_flag_o[0]), 32'h0);
  endtask

  task automatic t_stop_ignore;
    wr(0, 6, (32'd4 << 2) | 32'h2);
    chk("R10 no req", 32'(req_valid_o[0]), 32'h0);
    rd_chk("R10 addr kept", 0, 1, 32'h1004);
    rd_chk("R10 cnt kept", 0, 3, 32'd6);
    beat(0);
    rd_chk("R12 addr idle", 0, 1, 32'h1004);
    rd_chk("R12 irq idle", 0, 5, 32'd6);
    beat(1);
    rd_chk("R12 ch1 idle", 1, 1, 32'h0);
  endtask

  task automatic t_one_shot;
    wr(2, 0, 32'h2000);
    wr(2, 2, 32'd5);
    wr(2, 6, (32'd4 << 2) | 32'h1);
    rd_chk("R11 ch0 untouched", 0, 0, 32'h1000);
    rd_chk("R11 ch3 untouched", 3, 0, 32'h0);
    beat(2);
    chk("R3 tail len", len_of(2), 32'd1);
    beat(2);
    chk("R6 no req", 32'(req_valid_o[2]), 32'h0);
    rd_chk("R6 run clear", 2, 6, 32'h10);
    rd_chk("R6 end addr", 2, 1, 32'h2005);
    chk("R6 wrap clear", 32'(wrap_sts_o[2]), 32'h0);
    chk("R7 no irq", 32'(irq_flag_o[2]), 32'h0);
    wr(2, 6, (32'd4 << 2) | 32'h1);
    rd_chk("R2 restart addr", 2, 1, 32'h2000);
    rd_chk("R2 restart cnt", 2, 3, 32'd5);
    wr(3, 2, 32'd8);
    wr(3, 6, 32'h1);
    chk("R3 zero beat", 32'(req_valid_o[3]), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_loop_run();
    t_w1c();
    t_stop_ignore();
    t_one_shot();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule